// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Counter

This block is the control side of a small asynchronous dynamic memory, rebuilt on a fast system clock. The four active-low strobes (row strobe, column strobe, write enable, output enable) pass through two-flop synchronizers. Their edges are found by comparing each synchronized sample with the one before it. From the order of those edges the block sorts every memory cycle into one of four kinds: read, write, row-only refresh, or column-before-row refresh. It then steers a small byte array that stands in for the cell array.

The row address of a normal cycle is taken from the multiplexed address bus when the row strobe falls. The column address is taken when the column strobe falls. In a column-before-row refresh cycle the row comes from an internal 9-bit counter, the bus is ignored and the data pins stay undriven. The counter advances when such a cycle ends. A counter test input lets normal read and write cycles use the counter as their row, so that its value can be seen and checked through the array.

Only the low bits of the row and column select a byte in the stand-in array. `row_addr` shows the full row that the current or most recent cycle opened. `cyc_kind` shows how that cycle was classified.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, `dout_oe` is 0, `cyc_kind` is 0 (none) and the refresh counter holds 0.
- R2: When the row strobe falls while the column strobe is high, `row_addr` takes `addr`, `cyc_kind` becomes 3 (row-only), and `row_addr` stays fixed while the row strobe remains low.
- R3: A column strobe fall with write enable high makes `cyc_kind` 1 (read). `dout_oe` is then 1 while the row, column and output enable strobes are all low. `dout` shows the byte at row low bits and column low bits, where the array index is {row[2:0], col[2:0]}.
- R4: A column strobe fall with write enable already low makes `cyc_kind` 2 (write) and stores `din` at the addressed byte. `dout_oe` stays 0 for the whole cycle.
- R5: If write enable falls during a read while the column strobe is low, `cyc_kind` becomes 2, `din` is stored at the open byte, and `dout_oe` drops to 0.
- R6: A column strobe fall while the row strobe is high, followed by a row strobe fall, makes `cyc_kind` 4 (refresh). In that cycle `row_addr` equals the counter, `addr` is ignored, `dout_oe` stays 0 even with output enable low, and no array byte changes.
- R7: The counter increases by one when the row strobe rises at the end of a refresh cycle, and only then. It wraps from 511 to 0.
- R8: If the column strobe stays low from the end of one cycle through the next row strobe fall, the new cycle is not a refresh. `cyc_kind` becomes 3 and the counter does not change.
- R9: With `ctr_test` high at the row strobe fall of a normal cycle, `row_addr` takes the counter instead of `addr`, and the counter does not change.
- R10: During a read, `dout_oe` is 0 while output enable is high and becomes 1 once it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| ctr_test | input | 1 | Counter test mode: normal cycles take their row from the counter |
| addr | input | 9 | Multiplexed row/column address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Drive enable for the data pins |
| row_addr | output | 9 | Row opened by the current or most recent cycle |
| cyc_kind | output | 3 | 0 none, 1 read, 2 write, 3 row-only, 4 refresh |

## Verification
Every strobe change takes two clocks to pass the synchronizer and one more to show up in the registered state. Strobe-gated outputs such as `dout_oe` can therefore change after two clocks, and `cyc_kind`, `row_addr` and array writes after three. The bench changes inputs on a falling clock edge and waits four falling edges before it samples. The one-clock margin makes every check land after the result is due and before the next stimulus. Refresh counter values are never read directly. They are seen in `row_addr` during refresh and counter-test cycles, and in the array bytes those cycles write.

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl #(
  parameter int ROW_W  = 9,
  parameter int DATA_W = 8,
  parameter int ARR_RB = 3,
  parameter int ARR_CB = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ctr_test,
  input  logic [ROW_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [ROW_W-1:0]  row_addr,
  output logic [2:0]        cyc_kind
);
  localparam int IDX_W = ARR_RB + ARR_CB;
  localparam int DEPTH = 1 << IDX_W;

  localparam logic [2:0] K_NONE  = 3'd0;
  localparam logic [2:0] K_READ  = 3'd1;
  localparam logic [2:0] K_WRITE = 3'd2;
  localparam logic [2:0] K_RONLY = 3'd3;
  localparam logic [2:0] K_CBR   = 3'd4;

  typedef enum logic [1:0] {P_IDLE, P_ACC, P_CBR} phase_t;

  logic [3:0] s1, s2;
  logic [2:0] sp;
  phase_t     phase;
  logic       cbr_pend;
  logic [ROW_W-1:0]  cnt;
  logic [ARR_CB-1:0] col_q;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      sp <= '1;
    end else begin
      s1 <= {oe_n, we_n, cas_n, ras_n};
      s2 <= s1;
      sp <= s2[2:0];
    end
  end

  logic ras_s, cas_s, we_s, oe_s;
  assign ras_s = s2[0];
  assign cas_s = s2[1];
  assign we_s  = s2[2];
  assign oe_s  = s2[3];

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  assign ras_fall = sp[0] & ~ras_s;
  assign ras_rise = ~sp[0] & ras_s;
  assign cas_fall = sp[1] & ~cas_s;
  assign cas_rise = ~sp[1] & cas_s;
  assign we_fall  = sp[2] & ~we_s;

  logic in_acc, early_wr, late_wr, wr_en;
  logic [ARR_CB-1:0] wr_col;
  logic [IDX_W-1:0]  wr_idx;
  assign in_acc   = (phase == P_ACC) && !ras_fall && !ras_rise;
  assign early_wr = in_acc && cas_fall && !we_s;
  assign late_wr  = in_acc && !cas_fall && we_fall && !cas_s && (cyc_kind == K_READ);
  assign wr_en    = early_wr || late_wr;
  assign wr_col   = cas_fall ? addr[ARR_CB-1:0] : col_q;
  assign wr_idx   = {row_addr[ARR_RB-1:0], wr_col};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= P_IDLE;
      cbr_pend <= 1'b0;
      cnt      <= '0;
      row_addr <= '0;
      col_q    <= '0;
      cyc_kind <= K_NONE;
    end else if (ras_fall) begin
      cbr_pend <= 1'b0;
      if (cbr_pend && !cas_s) begin
        phase    <= P_CBR;
        cyc_kind <= K_CBR;
        row_addr <= cnt;
      end else begin
        phase    <= P_ACC;
        cyc_kind <= K_RONLY;
        row_addr <= ctr_test ? cnt : addr;
      end
    end else if (ras_rise) begin
      phase    <= P_IDLE;
      cbr_pend <= 1'b0;
      if (phase == P_CBR) cnt <= cnt + 1'b1;
    end else if (phase == P_IDLE) begin
      if (cas_fall)      cbr_pend <= 1'b1;
      else if (cas_rise) cbr_pend <= 1'b0;
    end else if (phase == P_ACC) begin
      if (cas_fall) begin
        col_q    <= addr[ARR_CB-1:0];
        cyc_kind <= we_s ? K_READ : K_WRITE;
      end else if (late_wr) begin
        cyc_kind <= K_WRITE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= din;
    end
  end

  assign dout    = mem[{row_addr[ARR_RB-1:0], col_q}];
  assign dout_oe = (phase == P_ACC) && (cyc_kind == K_READ) && !ras_s && !cas_s && !oe_s;
endmodule

// File: rtl/dram_strobe_ctrl_chk.sv
module dram_strobe_ctrl_chk #(
  parameter int ROW_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_s,
  input logic             dout_oe,
  input logic [2:0]       cyc_kind,
  input logic [ROW_W-1:0] row_addr,
  input logic [ROW_W-1:0] cnt
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1)); // R7
  AST_CNT_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ($past(cyc_kind) == 3'd4)); // R7
  AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_s && !$past(ras_s) && !$past(ras_s, 2)) |-> $stable(row_addr)); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd2) |-> !dout_oe); // R4
  AST_REFRESH_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind == 3'd4) |-> !dout_oe); // R6
endmodule

bind dram_strobe_ctrl dram_strobe_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_s(ras_s), .dout_oe(dout_oe),
  .cyc_kind(cyc_kind), .row_addr(row_addr), .cnt(cnt)
);

// File: tb/test_dram_strobe_ctrl.sv
module test_dram_strobe_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ctr_test = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [8:0] row_addr;
  logic [2:0] cyc_kind;

  int nchk = 0, nerr = 0;
  logic [7:0] mdl [64];
  logic [8:0] exp_cnt = '0;

  always #2.5 clk = ~clk;

  dram_strobe_ctrl i_dram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .ctr_test(ctr_test), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .row_addr(row_addr), .cyc_kind(cyc_kind)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ix(logic [8:0] r, logic [8:0] c);
    return {r[2:0], c[2:0]};
  endfunction

  task automatic end_cycle();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    chk("R1 kind", cyc_kind, 0);
    chk("R1 oe", dout_oe, 0);
  endtask

  task automatic t_write_early(logic [8:0] r, logic [8:0] c, logic [7:0] d);
    addr = r; ras_n = 1'b0; step(4);
    chk("R2 row", row_addr, r);
    chk("R2 kind", cyc_kind, 3);
    din = d; we_n = 1'b0; oe_n = 1'b0; step(4);
    addr = c; cas_n = 1'b0; step(4);
    chk("R4 kind", cyc_kind, 2);
    chk("R4 oe", dout_oe, 0);
    chk("R2 row held", row_addr, r);
    mdl[ix(r, c)] = d;
    end_cycle();
  endtask

  task automatic t_read(logic [8:0] r, logic [8:0] c, string req);
    addr = r; ras_n = 1'b0; step(4);
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step(4);
    chk({req, " kind"}, cyc_kind, 1);
    chk({req, " oe"}, dout_oe, 1);
    chk({req, " data"}, dout, mdl[ix(r, c)]);
    end_cycle();
  endtask

  task automatic t_oe_gate(logic [8:0] r, logic [8:0] c);
    addr = r; ras_n = 1'b0; step(4);
    addr = c; cas_n = 1'b0; step(4);
    chk("R10 oe high", dout_oe, 0);
    oe_n = 1'b0; step(4);
    chk("R10 oe low", dout_oe, 1);
    end_cycle();
  endtask

  task automatic t_rmw(logic [8:0] r, logic [8:0] c, logic [7:0] d);
    addr = r; ras_n = 1'b0; step(4);
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step(4);
    chk("R5 read first", dout_oe, 1);
    chk("R5 old data", dout, mdl[ix(r, c)]);
    oe_n = 1'b1; din = d; step(4);
    we_n = 1'b0; step(4);
    chk("R5 kind", cyc_kind, 2);
    chk("R5 oe", dout_oe, 0);
    mdl[ix(r, c)] = d;
    end_cycle();
  endtask

  task automatic t_cbr(bit do_chk, logic [8:0] junk);
    cas_n = 1'b0; step(4);
    addr = junk; din = 8'hEE; oe_n = 1'b0; we_n = 1'b0; ras_n = 1'b0; step(4);
    if (do_chk) begin
      chk("R6 kind", cyc_kind, 4);
      chk("R6 row", row_addr, exp_cnt);
      chk("R6 oe", dout_oe, 0);
    end
    ras_n = 1'b1; step(4);
    cas_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; step(4);
    exp_cnt = exp_cnt + 1'b1;
  endtask

  task automatic t_hidden();
    addr = 9'd4; ras_n = 1'b0; step(4);
    addr = 9'd2; oe_n = 1'b0; cas_n = 1'b0; step(4);
    ras_n = 1'b1; step(4);
    addr = 9'd6; ras_n = 1'b0; step(4);
    chk("R8 kind", cyc_kind, 3);
    chk("R8 row", row_addr, 9'd6);
    end_cycle();
  endtask

  task automatic t_ctr_test(logic [8:0] c, logic [7:0] d);
    ctr_test = 1'b1; addr = 9'h1F0; ras_n = 1'b0; step(4);
    chk("R9 row", row_addr, exp_cnt);
    ctr_test = 1'b0; din = d; we_n = 1'b0; step(4);
    addr = c; cas_n = 1'b0; step(4);
    mdl[ix(exp_cnt, c)] = d;
    end_cycle();
    t_read(exp_cnt, c, "R9 via array");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = '0;
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_write_early(9'd5, 9'd3, 8'hA5);
    t_read(9'd5, 9'd3, "R3");
    t_write_early(9'd13, 9'd15, 8'h3C);
    t_read(9'd13, 9'd15, "R3 second");
    t_read(9'd5, 9'd3, "R4 aliasing intact");
    t_oe_gate(9'd5, 9'd3);
    t_rmw(9'd2, 9'd1, 8'h77);
    t_read(9'd2, 9'd1, "R5 readback");
    t_cbr(1'b1, 9'd5);
    chk("R1 counter start", exp_cnt, 1);
    t_read(9'd5, 9'd3, "R6 array unchanged");
    t_cbr(1'b1, 9'd13);
    t_hidden();
    t_cbr(1'b1, 9'd0);
    chk("R8 counter unchanged", exp_cnt, 3);
    t_ctr_test(9'd7, 8'h5A);
    t_cbr(1'b1, 9'd1);
    while (exp_cnt != 9'd511) t_cbr(1'b0, 9'd0);
    t_cbr(1'b1, 9'd2);
    t_cbr(1'b1, 9'd3);
    chk("R7 wrapped", exp_cnt, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule